// File: doc/BRIEF.md
# I2C Byte FIFO Pair with Trigger Flags

This block buffers data bytes between the bit shifter of an I2C controller and a host register interface. A receive queue collects bytes that the shifter delivers and the host drains. A transmit queue collects bytes that the host writes and the shifter consumes. Each queue is 16 bytes deep and keeps bytes strictly in arrival order. The bus carries 8-bit bytes, most significant bit first, each followed by an acknowledge, and the block stores only the whole bytes.

Each queue has a level flag compared against a programmable trigger count. The receive flag rises once enough bytes have gathered. The host may then read that many bytes without checking occupancy between reads. The transmit flag rises while the transmit queue holds few enough bytes to leave room.

Both flags are sticky. The host clears a flag by writing 0 to its status bit. That clear is overruled on any edge where the trigger condition still holds after the edge. Sticky error bits record a push into a full queue and a pop from an empty one. A synchronous flush input empties both queues in one cycle.

Top module: `i2c_byte_fifo_pair`

## Requirements
- R1: Bytes pushed with `rx_push` are returned on `hst_rdata` at address 0 in arrival order. While address 0 is selected, `hst_rdata` shows the oldest byte combinationally. A cycle with `hst_rd` high at address 0 removes that byte at the clock edge. Reads at other addresses remove nothing.
- R2: A cycle with `hst_wr` high at address 0 appends `hst_wdata` to the transmit queue. `tx_byte` shows the oldest transmit byte, and a cycle with `tx_pop` high removes it.
- R3: Address 3 reads the receive occupancy and address 4 reads the transmit occupancy, each in the range 0 to 16 in bits 4:0. Both update on the edge that ends a push or a pop.
- R4: Address 2 is the status register:
  - bit 0: receive flag
  - bit 1: transmit flag
  - bit 2: receive overrun
  - bit 3: transmit overrun
  - bit 4: receive underrun
  - bit 5: transmit underrun

  Address 1 is the control register. Bits 3:0 hold the receive trigger field and bits 7:4 hold the transmit trigger field. Each trigger count equals its field value plus 1. The control register is writable and reads back.
- R5: Status bit 0 becomes 1 on the edge after which the receive occupancy is at or above the receive trigger count. The trigger used is the one held before that edge. The bit stays 1 after the occupancy falls.
- R6: Writing address 2 with bit 0 equal to 0 clears the receive flag. If the occupancy after that edge is still at or above the trigger count, the flag reads 1 instead.
- R7: Status bit 1 becomes 1 on the edge after which the transmit occupancy is at or below the transmit trigger count. It is sticky in the same way. Writing 0 to bit 1 clears it, except when the condition still holds after the edge.
- R8: A push into a queue holding 16 bytes, with no pop on that side in the same cycle, is dropped. The queue contents are unchanged and the overrun bit of that side is set.
- R9: A pop from an empty queue returns 0 on `hst_rdata` (receive) or `tx_byte` (transmit). The occupancy stays 0 and the underrun bit of that side is set.
- R10: Status bits 2 to 5 are sticky. Writing address 2 with a 0 in a bit position clears that bit. A 1 in that position leaves it unchanged.
- R11: `flush` empties both queues and clears all six status bits on one edge, and the control register keeps its value. The transmit flag rises again on the next edge, because an empty queue is below any trigger count.
- R12: A push and a pop on the same non-empty side in one cycle leave the occupancy unchanged and keep the byte order. A full queue accepts a push that is paired with a pop.
- R13: After reset both occupancies, the status register and the control register read 0. The transmit flag reads 1 after the first edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous empty of both queues and status |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | Shifter takes the oldest transmit byte |
| tx_byte | output | 8 | Oldest transmit byte, 0 when empty |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe (pops only at address 0) |
| hst_addr | input | 3 | Host register address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data for the selected address |

## Verification
Several properties are checked on every cycle:
- the occupancy bound
- the set condition of both flags while the trigger field is stable
- the stickiness of the overrun bit
- the flush result
- the unchanged count on a paired push and pop
- the zero returned by an empty queue

Other behaviours only the bench scenarios can show. These are byte ordering through full and wrapped queues, the write-0-to-clear encoding against the override rule, and the exact status word after a mix of errors. The behavioural queue model catches these by comparing the read data and the transmit head on every cycle.

// File: rtl/i2c_byte_fifo_pair.sv
module i2c_byte_fifo_pair #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int TRW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_byte,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_byte,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic [2:0]    hst_addr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [2:0] A_DATA = 3'd0, A_CTRL = 3'd1, A_STAT = 3'd2,
                         A_RXCNT = 3'd3, A_TXCNT = 3'd4;

  logic [2*TRW-1:0]      ctrl;
  logic [5:0]            sts;
  logic [1:0]            push, pop;
  logic [1:0][DW-1:0]    din;
  logic [1:0][TRW-1:0]   tfield;
  logic [CW-1:0]         rx_cnt, tx_cnt;
  logic [DW-1:0]         rx_head;

  wire       stat_wr = hst_wr && (hst_addr == A_STAT);
  wire [5:0] clr     = stat_wr ? ~hst_wdata[5:0] : 6'd0;

  assign push   = {hst_wr && (hst_addr == A_DATA), rx_push};
  assign pop    = {tx_pop, hst_rd && (hst_addr == A_DATA)};
  assign din    = {hst_wdata, rx_byte};
  assign tfield = {ctrl[2*TRW-1:TRW], ctrl[TRW-1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              ctrl <= '0;
    else if (hst_wr && (hst_addr == A_CTRL)) ctrl <= hst_wdata[2*TRW-1:0];

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] c, c_nx, trig;
    logic          empty, full, do_pop, do_push, hit;
    logic          flg, ovr, udr;
    logic [DW-1:0] head;

    assign empty   = (c == '0);
    assign full    = (c == CW'(DEPTH));
    assign do_pop  = pop[s] & ~empty;
    assign do_push = push[s] & (~full | do_pop);
    assign c_nx    = c + CW'(do_push) - CW'(do_pop);
    assign trig    = CW'(tfield[s]) + CW'(1);
    assign head    = empty ? '0 : mem[rp];

    if (s == 0) begin : g_rx
      assign hit = (c_nx >= trig);
    end else begin : g_tx
      assign hit = (c_nx <= trig);
    end

    always_ff @(posedge clk)
      if (do_push && !flush) mem[wp] <= din[s];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        rp <= '0; wp <= '0; c <= '0;
        flg <= 1'b0; ovr <= 1'b0; udr <= 1'b0;
      end else if (flush) begin
        rp <= '0; wp <= '0; c <= '0;
        flg <= 1'b0; ovr <= 1'b0; udr <= 1'b0;
      end else begin
        if (do_push) wp <= wp + AW'(1);
        if (do_pop)  rp <= rp + AW'(1);
        c   <= c_nx;
        flg <= hit | (flg & ~clr[s]);
        ovr <= (ovr & ~clr[2+s]) | (push[s] & ~do_push);
        udr <= (udr & ~clr[4+s]) | (pop[s] & empty);
      end
  end

  assign rx_cnt  = g_side[0].c;
  assign tx_cnt  = g_side[1].c;
  assign rx_head = g_side[0].head;
  assign tx_byte = g_side[1].head;
  assign sts = {g_side[1].udr, g_side[0].udr, g_side[1].ovr,
                g_side[0].ovr, g_side[1].flg, g_side[0].flg};

  always_comb begin
    case (hst_addr)
      A_DATA:  hst_rdata = rx_head;
      A_CTRL:  hst_rdata = DW'(ctrl);
      A_STAT:  hst_rdata = DW'(sts);
      A_RXCNT: hst_rdata = DW'(rx_cnt);
      A_TXCNT: hst_rdata = DW'(tx_cnt);
      default: hst_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_byte_fifo_pair_chk.sv
module i2c_byte_fifo_pair_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int TRW   = 4,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             rx_push,
  input logic             hst_wr,
  input logic             hst_rd,
  input logic [2:0]       hst_addr,
  input logic [DW-1:0]    hst_wdata,
  input logic [DW-1:0]    hst_rdata,
  input logic [DW-1:0]    tx_byte,
  input logic [CW-1:0]    rx_cnt,
  input logic [CW-1:0]    tx_cnt,
  input logic [2*TRW-1:0] ctrl,
  input logic [5:0]       sts
);
  logic [CW-1:0] rx_lvl, tx_lvl;
  assign rx_lvl = CW'(ctrl[TRW-1:0]) + CW'(1);
  assign tx_lvl = CW'(ctrl[2*TRW-1:TRW]) + CW'(1);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH))); // R3
  AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(flush) && $stable(ctrl) && rx_cnt >= rx_lvl) |-> sts[0]); // R5
  AST_TX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(flush) && $stable(ctrl) && tx_cnt <= tx_lvl) |-> sts[1]); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[2] && !flush && !(hst_wr && hst_addr == 3'd2 && !hst_wdata[2])) |=> sts[2]); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rx_cnt == '0 && tx_cnt == '0 && sts == 6'd0)); // R11
  AST_PAIR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && hst_rd && hst_addr == 3'd0 && rx_cnt != '0 && !flush) |=> $stable(rx_cnt)); // R12
  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && hst_addr == 3'd0) |-> hst_rdata == '0); // R9
  AST_TX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == '0) |-> tx_byte == '0); // R9
endmodule

bind i2c_byte_fifo_pair i2c_byte_fifo_pair_chk #(.DEPTH(DEPTH), .DW(DW), .TRW(TRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .rx_push(rx_push),
  .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
  .hst_rdata(hst_rdata), .tx_byte(tx_byte), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
  .ctrl(ctrl), .sts(sts));

// File: tb/tb_i2c_byte_fifo_pair.sv
module tb_i2c_byte_fifo_pair;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic rx_push = 1'b0, tx_pop = 1'b0, hst_wr = 1'b0, hst_rd = 1'b0;
  logic [2:0] hst_addr = 3'd0;
  logic [7:0] rx_byte = 8'd0, hst_wdata = 8'd0;
  logic [7:0] tx_byte, hst_rdata;

  i2c_byte_fifo_pair dut (.clk(clk), .rst_n(rst_n), .flush(flush),
    .rx_push(rx_push), .rx_byte(rx_byte), .tx_pop(tx_pop), .tx_byte(tx_byte),
    .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] rs, ts, d;

  logic [7:0] rxq[$], txq[$];
  bit mflag[2], movr[2], mudr[2];
  logic [7:0] mctrl = 8'd0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata();
    case (hst_addr)
      3'd0: return (rxq.size() > 0) ? rxq[0] : 8'd0;
      3'd1: return mctrl;
      3'd2: return {2'b00, mudr[1], mudr[0], movr[1], movr[0], mflag[1], mflag[0]};
      3'd3: return 8'(rxq.size());
      3'd4: return 8'(txq.size());
      default: return 8'd0;
    endcase
  endfunction

  task automatic model_update();
    bit [5:0] clr;
    int trx, ttx;
    bit pp, ps, e, pok, sok;
    clr = (hst_wr && hst_addr == 3'd2) ? ~hst_wdata[5:0] : 6'd0;
    trx = int'(mctrl[3:0]) + 1;
    ttx = int'(mctrl[7:4]) + 1;
    if (flush) begin
      rxq.delete(); txq.delete();
      for (int i = 0; i < 2; i++) begin mflag[i] = 0; movr[i] = 0; mudr[i] = 0; end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (clr[i]) mflag[i] = 0;
        if (clr[2+i]) movr[i] = 0;
        if (clr[4+i]) mudr[i] = 0;
      end
      pp = hst_rd && hst_addr == 3'd0; ps = rx_push; e = (rxq.size() == 0);
      pok = pp && !e; sok = ps && (rxq.size() < 16 || pok);
      if (pok) void'(rxq.pop_front());
      if (sok) rxq.push_back(rx_byte);
      if (ps && !sok) movr[0] = 1;
      if (pp && e) mudr[0] = 1;
      if (rxq.size() >= trx) mflag[0] = 1;
      pp = tx_pop; ps = hst_wr && hst_addr == 3'd0; e = (txq.size() == 0);
      pok = pp && !e; sok = ps && (txq.size() < 16 || pok);
      if (pok) void'(txq.pop_front());
      if (sok) txq.push_back(hst_wdata);
      if (ps && !sok) movr[1] = 1;
      if (pp && e) mudr[1] = 1;
      if (txq.size() <= ttx) mflag[1] = 1;
    end
    if (hst_wr && hst_addr == 3'd1) mctrl = hst_wdata;
  endtask

  task automatic cyc();
    string tag;
    #1;
    rs = hst_rdata; ts = tx_byte;
    if (rst_n) begin
      case (hst_addr)
        3'd0: tag = "R1";
        3'd1: tag = "R4";
        3'd2: tag = "R5";
        default: tag = "R3";
      endcase
      check(tag, rs, exp_rdata());
      check("R2", ts, (txq.size() > 0) ? txq[0] : 0);
    end
    @(posedge clk);
    if (rst_n) model_update();
    @(negedge clk);
  endtask

  task automatic push_rx(logic [7:0] b);
    rx_push = 1; rx_byte = b; cyc(); rx_push = 0;
  endtask
  task automatic hwr(logic [2:0] a, logic [7:0] v);
    hst_wr = 1; hst_addr = a; hst_wdata = v; cyc(); hst_wr = 0;
  endtask
  task automatic hrd(logic [2:0] a, output logic [7:0] v);
    hst_rd = 1; hst_addr = a; cyc(); v = rs; hst_rd = 0;
  endtask
  task automatic peek(logic [2:0] a, output logic [7:0] v);
    hst_addr = a; cyc(); v = rs;
  endtask
  task automatic txp(output logic [7:0] v);
    tx_pop = 1; cyc(); v = ts; tx_pop = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    peek(2, d); check("R13", d, 8'h00);
    peek(2, d); check("R13", d, 8'h02);
    peek(3, d); check("R13", d, 0);
    peek(1, d); check("R13", d, 0);

    push_rx(8'hA1); push_rx(8'hB2); push_rx(8'hC3);
    peek(3, d); check("R3", d, 3);
    hrd(2, d); peek(3, d); check("R1", d, 3);
    hrd(0, d); check("R1", d, 8'hA1);
    hrd(0, d); check("R1", d, 8'hB2);
    hrd(0, d); check("R1", d, 8'hC3);
    peek(2, d); check("R5", d, 8'h03);
    hwr(2, 8'hFC); peek(2, d); check("R7", d, 8'h02);

    hwr(1, 8'h13); peek(1, d); check("R4", d, 8'h13);
    push_rx(8'h10); push_rx(8'h11); push_rx(8'h12);
    peek(2, d); check("R5", d, 8'h02);
    push_rx(8'h13); peek(2, d); check("R5", d, 8'h03);
    hwr(2, 8'hFE); peek(2, d); check("R6", d, 8'h03);
    hrd(0, d); check("R1", d, 8'h10);
    peek(2, d); check("R5", d, 8'h03);
    hwr(2, 8'hFE); peek(2, d); check("R6", d, 8'h02);
    for (int i = 1; i < 4; i++) begin hrd(0, d); check("R1", d, 8'h10 + i); end

    hwr(0, 8'h55); hwr(0, 8'h66); hwr(0, 8'h77);
    hwr(2, 8'hFD); peek(2, d); check("R7", d, 8'h00);
    peek(4, d); check("R3", d, 3);
    txp(d); check("R2", d, 8'h55);
    peek(2, d); check("R7", d, 8'h02);
    txp(d); check("R2", d, 8'h66);
    txp(d); check("R2", d, 8'h77);
    peek(4, d); check("R3", d, 0);

    for (int i = 0; i < 16; i++) push_rx(8'h20 + 8'(i));
    peek(3, d); check("R3", d, 16);
    push_rx(8'hEE);
    peek(3, d); check("R8", d, 16);
    peek(2, d); check("R8", d, 8'h07);
    for (int i = 0; i < 16; i++) begin hrd(0, d); check("R8", d, 8'h20 + i); end

    hrd(0, d); check("R9", d, 0);
    txp(d); check("R9", d, 0);
    peek(3, d); check("R9", d, 0);
    peek(2, d); check("R9", d, 8'h37);

    hwr(2, 8'hFB); peek(2, d); check("R10", d, 8'h33);
    hwr(2, 8'hFF); peek(2, d); check("R10", d, 8'h33);
    hwr(2, 8'h00); peek(2, d); check("R10", d, 8'h02);

    push_rx(8'h30); push_rx(8'h31);
    rx_push = 1; rx_byte = 8'h32; hst_rd = 1; hst_addr = 0; cyc();
    check("R12", rs, 8'h30); rx_push = 0; hst_rd = 0;
    peek(3, d); check("R12", d, 2);
    hrd(0, d); check("R12", d, 8'h31);
    hrd(0, d); check("R12", d, 8'h32);
    for (int i = 0; i < 16; i++) push_rx(8'h40 + 8'(i));
    rx_push = 1; rx_byte = 8'h50; hst_rd = 1; hst_addr = 0; cyc();
    check("R12", rs, 8'h40); rx_push = 0; hst_rd = 0;
    peek(3, d); check("R12", d, 16);
    peek(2, d); check("R12", d, 8'h03);
    for (int i = 1; i < 17; i++) begin hrd(0, d); check("R12", d, 8'h40 + i); end
    hwr(0, 8'h60);
    hst_wr = 1; hst_addr = 0; hst_wdata = 8'h61; tx_pop = 1; cyc();
    check("R12", ts, 8'h60); hst_wr = 0; tx_pop = 0;
    peek(4, d); check("R12", d, 1);
    txp(d); check("R12", d, 8'h61);

    push_rx(8'h70); push_rx(8'h71); hwr(0, 8'h72);
    flush = 1; cyc(); flush = 0;
    peek(2, d); check("R11", d, 8'h00);
    peek(3, d); check("R11", d, 0);
    peek(4, d); check("R11", d, 0);
    peek(1, d); check("R11", d, 8'h13);
    peek(2, d); check("R11", d, 8'h02);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule